// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer whose fill level is compared against an 8-bit programmable threshold. Two flags report the outcome: one is raised when the stored word count exactly equals the threshold, and one while the count is at or above it. Together they replace dedicated almost-full and almost-empty outputs. A producer watches the at-or-above flag to throttle early. A consumer can use the inverted at-or-above flag as a low-water mark.

The threshold input is always 8 bits wide. When the FIFO depth exceeds 256 words, the threshold value is scaled up by DEPTH/256 so that its range covers the whole buffer. With a depth of 512 the effective threshold steps by 2, and with 1024 it steps by 4. The read port is first-word fall-through: the oldest stored word is presented on the read data output whenever the FIFO is not empty.

Top module: `lvl_fifo`

## Requirements
- R1: After the asynchronous active-low reset, the FIFO holds no words: empty_o is 1 and full_o is 0.
- R2: Words leave in the order they were written. While empty_o is 0, rd_data_o shows the oldest stored word, without waiting for a read strobe.
- R3: A write while full_o is 1 is ignored. The stored count and the stored contents are unchanged, and full_o stays 1.
- R4: A read while empty_o is 1 is ignored. The stored count is unchanged, and empty_o stays 1 unless a write is accepted in the same cycle.
- R5: A read and a write accepted in the same cycle leave the count unchanged. The written word is appended and the oldest word is removed.
- R6: full_o is 1 exactly when DEPTH words are stored. empty_o is 1 exactly when none are stored. The two are never 1 together.
- R7: The effective threshold is level_i multiplied by DEPTH/256 when DEPTH exceeds 256, and level_i unchanged otherwise. With the default DEPTH of 512, the threshold is 2*level_i.
- R8: eq_th_o is 1 exactly when the stored count equals the effective threshold.
- R9: ge_th_o is 1 exactly when the stored count is greater than or equal to the effective threshold.
- R10: With level_i equal to 0, ge_th_o is always 1 and eq_th_o is 1 only while the FIFO is empty.
- R11: The flags follow a registered count, so they change in the cycle after the accepted write or read that moves the count. They follow a change of level_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Word to store |
| full_o | output | 1 | All DEPTH entries are occupied |
| rd_en_i | input | 1 | Read strobe (pops the head word) |
| rd_data_o | output | DATA_W | Oldest stored word |
| empty_o | output | 1 | No entries are occupied |
| level_i | input | LEVEL_W | Programmable threshold before scaling |
| eq_th_o | output | 1 | Count equals the scaled threshold |
| ge_th_o | output | 1 | Count is at or above the scaled threshold |

## Verification
The assertions assume that level_i is held steady across the cycle in which a count step is checked. They also assume that the strobes are plain 0/1 values sampled at the rising edge, and they make no assumption about how often the strobes are raised. The stimulus changes level_i only while both strobes are low. It drives every input half a period away from the active edge. It deliberately pairs strobes with full or empty states so that the ignore rules are exercised, rather than avoiding those states.

// File: rtl/lvl_fifo_pkg.sv
package lvl_fifo_pkg;
  // left shift that stretches an LW-bit level over a 2**n-deep buffer
  function automatic int unsigned lvl_shift(int unsigned depth, int unsigned lw);
    if (depth > (1 << lw)) return $clog2(depth) - lw;
    return 0;
  endfunction
endpackage

// File: rtl/lvl_fifo_ctrl.sv
module lvl_fifo_ctrl #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  assign full_o  = (count_q == FULL_CNT);
  assign empty_o = (count_q == '0);
  assign wr_ok_o = wr_en_i && !full_o;
  assign rd_ok_o = rd_en_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_ok_o) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (rd_ok_o) rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({wr_ok_o, rd_ok_o})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign count_o  = count_q;
endmodule

// File: rtl/lvl_fifo_mem.sv
module lvl_fifo_mem #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // fall-through read of the head entry
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lvl_fifo_thresh.sv
module lvl_fifo_thresh #(
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned LEVEL_W = 8,
  localparam int unsigned CW = $clog2(DEPTH) + 1,
  localparam int unsigned SH = lvl_fifo_pkg::lvl_shift(DEPTH, LEVEL_W),
  localparam int unsigned SW = LEVEL_W + SH,
  localparam int unsigned TW = (CW > SW) ? CW : SW
) (
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [CW-1:0]      count_i,
  output logic               eq_o,
  output logic               ge_o
);
  logic [SW-1:0] scaled;
  logic [TW-1:0] thr_w, cnt_w;

  generate
    if (SH > 0) begin : g_scale
      assign scaled = {level_i, {SH{1'b0}}};
    end else begin : g_plain
      assign scaled = level_i;
    end
  endgenerate

  assign thr_w = TW'(scaled);
  assign cnt_w = TW'(count_i);
  assign eq_o  = (cnt_w == thr_w);
  assign ge_o  = (cnt_w >= thr_w);
endmodule

// File: rtl/lvl_fifo.sv
module lvl_fifo #(
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LEVEL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               full_o,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               empty_o,
  input  logic [LEVEL_W-1:0] level_i,
  output logic               eq_th_o,
  output logic               ge_th_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  lvl_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .wr_ok_o (wr_ok),
    .rd_ok_o (rd_ok),
    .wr_ptr_o(wr_ptr),
    .rd_ptr_o(rd_ptr),
    .count_o (count_q),
    .full_o  (full_o),
    .empty_o (empty_o)
  );

  lvl_fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_ok),
    .waddr_i(wr_ptr),
    .wdata_i(wr_data_i),
    .raddr_i(rd_ptr),
    .rdata_o(rd_data_o)
  );

  lvl_fifo_thresh #(.DEPTH(DEPTH), .LEVEL_W(LEVEL_W)) u_thr (
    .level_i(level_i),
    .count_i(count_q),
    .eq_o   (eq_th_o),
    .ge_o   (ge_th_o)
  );
endmodule

// File: rtl/lvl_fifo_chk.sv
module lvl_fifo_chk #(
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned LEVEL_W = 8,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic               full_o,
  input logic               empty_o,
  input logic [LEVEL_W-1:0] level_i,
  input logic               eq_th_o,
  input logic               ge_th_o,
  input logic [CW-1:0]      count_q
);
  p_full_empty_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_wr_full_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i) |=> ($stable(count_q) && full_o));

  p_rd_empty_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && !wr_en_i) |=> ($stable(count_q) && empty_o));

  p_both_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_o && !empty_o && wr_en_i && rd_en_i) |=> $stable(count_q));

  p_step_up_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_o && wr_en_i && !rd_en_i) |=> (count_q == $past(count_q) + CW'(1)));

  p_eq_in_ge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_th_o |-> ge_th_o);

  p_lvl_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |-> (ge_th_o && (eq_th_o == empty_o)));
endmodule

bind lvl_fifo lvl_fifo_chk #(.DEPTH(DEPTH), .LEVEL_W(LEVEL_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .full_o (full_o),
  .empty_o(empty_o),
  .level_i(level_i),
  .eq_th_o(eq_th_o),
  .ge_th_o(ge_th_o),
  .count_q(count_q)
);

// File: tb/sim_lvl_fifo.sv
module sim_lvl_fifo;
  localparam int DEPTH = 512;
  localparam int DW    = 8;
  localparam int SCALE = (DEPTH > 256) ? DEPTH / 256 : 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [7:0]    level_i = '0;
  logic          full_o, empty_o, eq_th_o, ge_th_o;

  int errors = 0, checks = 0;
  bit done = 0;
  int mq[$];

  always #2 clk_i = ~clk_i;

  lvl_fifo #(.DEPTH(DEPTH), .DATA_W(DW), .LEVEL_W(8)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    int thr = int'(level_i) * SCALE;
    int n = mq.size();
    chk(eq_th_o == (n == thr), req, int'(eq_th_o), int'(n == thr));
    chk(ge_th_o == (n >= thr), req, int'(ge_th_o), int'(n >= thr));
  endtask

  task automatic cyc(input bit w, input bit r, input logic [DW-1:0] d);
    bit wok, rok;
    @(negedge clk_i);
    wr_en_i = w; rd_en_i = r; wr_data_i = d;
    wok = w && (mq.size() < DEPTH);
    rok = r && (mq.size() > 0);
    @(negedge clk_i);
    wr_en_i = 0; rd_en_i = 0;
    if (rok) void'(mq.pop_front());
    if (wok) mq.push_back(int'(d));
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    mq.delete();
  endtask

  task automatic t_reset();
    do_reset();
    chk(empty_o == 1, "R1 empty", int'(empty_o), 1);
    chk(full_o == 0, "R1 full", int'(full_o), 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 6; i++) cyc(1, 0, DW'(8'h30 + i * 7));
    for (int i = 0; i < 6; i++) begin
      chk(int'(rd_data_o) == mq[0], "R2 head", int'(rd_data_o), mq[0]);
      cyc(0, 1, '0);
    end
    chk(empty_o == 1, "R6 empty after drain", int'(empty_o), 1);
  endtask

  task automatic t_underflow();
    cyc(0, 1, '0);
    chk(empty_o == 1, "R4 read empty", int'(empty_o), 1);
    cyc(1, 1, 8'h5a);
    chk(empty_o == 0 && int'(rd_data_o) == 8'h5a, "R4 rd+wr on empty",
        int'(rd_data_o), 8'h5a);
    cyc(0, 1, '0);
  endtask

  task automatic t_simul();
    cyc(1, 0, 8'h11);
    cyc(1, 0, 8'h22);
    cyc(1, 1, 8'h33);
    chk(mq.size() == 2 && int'(rd_data_o) == 8'h22, "R5 head after rd+wr",
        int'(rd_data_o), 8'h22);
    level_i = 8'd1;
    #0;
    chk_flags("R5 count 2 vs thr 2");
    level_i = 8'd0;
    cyc(0, 1, '0);
    cyc(0, 1, '0);
    chk(empty_o == 1, "R5 drained", int'(empty_o), 1);
  endtask

  task automatic t_thresh();
    level_i = 8'd5;  // scaled threshold 10
    for (int i = 0; i < 9; i++) cyc(1, 0, DW'(i));
    chk_flags("R9 below thr");
    cyc(1, 0, 8'h77);
    chk(eq_th_o == 1, "R8 eq at thr (R11 next cycle)", int'(eq_th_o), 1);
    chk_flags("R7 scaled thr");
    cyc(1, 0, 8'h78);
    chk_flags("R9 above thr");
    level_i = 8'd6;
    #1;
    chk(ge_th_o == 0, "R11 level change same cycle", int'(ge_th_o), 0);
    level_i = 8'd0;
    #1;
    chk(ge_th_o == 1 && eq_th_o == 0, "R10 level zero nonempty",
        int'({eq_th_o, ge_th_o}), 1);
    while (mq.size() > 0) cyc(0, 1, '0);
    chk(eq_th_o == 1 && ge_th_o == 1, "R10 level zero empty",
        int'({eq_th_o, ge_th_o}), 3);
  endtask

  task automatic t_overflow();
    int head;
    level_i = 8'd255;
    for (int i = 0; i < DEPTH - 1; i++) cyc(1, 0, DW'(i * 3));
    chk(full_o == 0, "R6 not full at DEPTH-1", int'(full_o), 0);
    cyc(1, 0, 8'hee);
    chk(full_o == 1, "R6 full at DEPTH", int'(full_o), 1);
    chk_flags("R9 full vs top level");
    head = mq[0];
    cyc(1, 0, 8'hab);
    chk(full_o == 1 && int'(rd_data_o) == head, "R3 write when full",
        int'(rd_data_o), head);
    cyc(1, 1, 8'hcd);
    chk(full_o == 0, "R3 rd+wr on full keeps only read", int'(full_o), 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (int'(rd_data_o) != mq[0]) chk(0, "R3 drain contents", int'(rd_data_o), mq[0]);
      cyc(0, 1, '0);
    end
    checks++;
    chk(empty_o == 1, "R3 dropped word absent", int'(empty_o), 1);
    level_i = 8'd0;
  endtask

  initial begin
    t_reset();
    t_order();
    t_underflow();
    t_simul();
    t_thresh();
    t_overflow();
    t_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule